// File: doc/BRIEF.md
# Debug Bus Trigger Unit

This unit sits beside a processor core and watches two buses: the instruction-fetch address bus and the data bus, which carries an address, a data word and read/write qualifiers. It holds four programmable trigger slots. Each slot compares the transfer on its chosen bus against its stored conditions and, on a match, launches one or more debug actions. The actions are a break pulse that hands the core to the debugger, an external trigger pulse, trace on, trace off, a single trace-sample strobe, and arming another slot.

Slots can be chained. One slot's arm action sets a latched flag on a target slot, and a slot that requires arming fires only once that flag is set. This gives two-level "event A, then event B" sequencing. An even slot can also take over its odd neighbour so that the pair checks an inclusive span of data-bus addresses or data values. Software programs the slots through a simple write-only register port. The outputs feed the core's halt logic, a cross-trigger pin and an external trace capture block.

Top module: `dbg_trigger_unit`

## Requirements
- R1: After reset all outputs are low, no slot is armed and every slot is disabled, so no transfer fires any action.
- R2: A programming write (cfg_we=1) updates the field chosen by cfg_sel (0 control, 1 compare address, 2 compare data) of slot cfg_slot at the clock edge. The control word bits are: 0 enable, 1 data bus (else instruction bus), 2 match address, 3 match data, 4 require read, 5 require write, 6 require armed, 7 range mode, 8 range on data value (else on address), 16 break, 17 external trigger, 18 trace on, 19 trace off, 20 trace sample, 21 arm, and 27:24 arm target slot.
- R3: An instruction-bus slot with address matching fires when i_valid is high and i_addr equals its address. break_o goes high for exactly one cycle, in the cycle after the transfer. Data-bus transfers never match it.
- R4: On a data-bus slot, all enabled conditions (address equal, data equal, read, write) must hold at the same time for the slot to fire.
- R5: A slot with the enable bit clear never fires, whatever its other settings.
- R6: In range mode an even slot uses the data bus and matches when the selected quantity lies between its own value and the next slot's value, both bounds included. While the pair is formed, the odd slot never fires on its own.
- R7: A firing slot with the arm action sets the armed flag of its target slot, and the flag shows on armed_o in the cycle after the transfer. A slot that requires arming fires only while its own flag is set.
- R8: An armed flag stays set until a control-word write to that slot clears it. Writes to the address or data fields leave it set.
- R9: trace_en_o is set by a trace-on action and cleared by a trace-off action, and holds between them. If both actions occur on the same transfer, trace_en_o becomes 0.
- R10: trace_sample_o pulses only for slots bound to the data bus. A sample action on an instruction-bus slot has no effect.
- R11: ext_trig_o goes high for exactly one cycle, in the cycle after a matching transfer of a slot with the external-trigger action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Instruction-bus transfer strobe |
| i_addr | input | 32 | Instruction fetch address |
| d_valid | input | 1 | Data-bus transfer strobe |
| d_addr | input | 32 | Data-bus address |
| d_data | input | 32 | Data-bus data word |
| d_rd | input | 1 | Data-bus read qualifier |
| d_wr | input | 1 | Data-bus write qualifier |
| cfg_we | input | 1 | Programming write strobe |
| cfg_slot | input | 2 | Slot index of the write |
| cfg_sel | input | 2 | Field select: 0 control, 1 address, 2 data |
| cfg_wdata | input | 32 | Programming write data |
| break_o | output | 1 | Break request pulse |
| ext_trig_o | output | 1 | External trigger pulse |
| trace_en_o | output | 1 | Sticky trace-enable flag |
| trace_sample_o | output | 1 | Single trace-sample strobe |
| armed_o | output | 4 | Per-slot armed flags |

## Verification
The hardest situation to reach is the two-level sequence. A dependent slot must be shown to stay silent before its arming event, to fire after it, to keep firing while the flag is latched, and to fall silent again after a control write while surviving a write to a compare field. The stimulus programs an arming slot and a dependent slot, then plays the dependent address before the arming address, between writes and again afterwards. The inclusive range is driven exactly on both bounds and one step outside them. In the same pass the consumed neighbour slot is given a matching condition of its own, to show it stays quiet.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    localparam int TGT_W = 4;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2
    } cfg_sel_e;

    // Condition half of a control word (bits 8:0)
    typedef struct packed {
        logic range_data;
        logic range;
        logic m_arm;
        logic m_wr;
        logic m_rd;
        logic m_data;
        logic m_addr;
        logic dbus;
        logic en;
    } cond_t;

    // Action half of a control word (bits 27:24 and 21:16)
    typedef struct packed {
        logic [TGT_W-1:0] arm_tgt;
        logic             arm;
        logic             smp;
        logic             toff;
        logic             ton;
        logic             ext;
        logic             brk;
    } act_t;

    typedef struct packed {
        act_t  act;
        cond_t cond;
    } ctrl_t;

endpackage

// File: rtl/dbg_trig_cfg_store.sv
module dbg_trig_cfg_store
    import dbg_trig_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int CW      = 32,
    parameter int IW      = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IW-1:0]                slot,
    input  logic [1:0]                   sel,
    input  logic [CW-1:0]                wdata,
    output ctrl_t [N_SLOTS-1:0]          ctrl_o,
    output logic  [N_SLOTS-1:0][AW-1:0]  addr_o,
    output logic  [N_SLOTS-1:0][DW-1:0]  data_o,
    output logic  [N_SLOTS-1:0]          ctrl_wr_o
);

    typedef struct packed {
        ctrl_t [N_SLOTS-1:0]          ctrl;
        logic  [N_SLOTS-1:0][AW-1:0]  addr;
        logic  [N_SLOTS-1:0][DW-1:0]  data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        ctrl_wr_o = '0;
        if (we) begin
            for (int i = 0; i < N_SLOTS; i++) begin
                if (slot == IW'(i)) begin
                    case (cfg_sel_e'(sel))
                        SEL_CTRL: begin
                            st_d.ctrl[i].cond = cond_t'(wdata[8:0]);
                            st_d.ctrl[i].act  = act_t'({wdata[27:24], wdata[21:16]});
                            ctrl_wr_o[i]      = 1'b1;
                        end
                        SEL_ADDR: st_d.addr[i] = wdata[AW-1:0];
                        SEL_DATA: st_d.data[i] = wdata[DW-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign addr_o = st_q.addr;
    assign data_o = st_q.data;

endmodule

// File: rtl/dbg_trig_slot_match.sv
module dbg_trig_slot_match
    import dbg_trig_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter bit HAS_PAIR = 1'b0
) (
    input  cond_t          cond,
    input  logic [AW-1:0]  lo_addr,
    input  logic [DW-1:0]  lo_data,
    input  logic [AW-1:0]  hi_addr,
    input  logic [DW-1:0]  hi_data,
    input  logic           consumed,
    input  logic           armed,
    input  logic           i_valid,
    input  logic [AW-1:0]  i_addr,
    input  logic           d_valid,
    input  logic [AW-1:0]  d_addr,
    input  logic [DW-1:0]  d_data,
    input  logic           d_rd,
    input  logic           d_wr,
    output logic           on_dbus_o,
    output logic           hit_o
);

    logic          use_range;
    logic          bus_valid;
    logic [AW-1:0] bus_addr;
    logic          addr_ok, data_ok, rd_ok, wr_ok, arm_ok;

    always_comb begin
        use_range = HAS_PAIR && cond.range;
        on_dbus_o = cond.dbus || use_range;
        bus_valid = on_dbus_o ? d_valid : i_valid;
        bus_addr  = on_dbus_o ? d_addr  : i_addr;

        if (use_range && !cond.range_data)
            addr_ok = (bus_addr >= lo_addr) && (bus_addr <= hi_addr);
        else
            addr_ok = !cond.m_addr || (bus_addr == lo_addr);

        if (!on_dbus_o)
            data_ok = 1'b1;
        else if (use_range && cond.range_data)
            data_ok = (d_data >= lo_data) && (d_data <= hi_data);
        else
            data_ok = !cond.m_data || (d_data == lo_data);

        rd_ok  = !on_dbus_o || !cond.m_rd || d_rd;
        wr_ok  = !on_dbus_o || !cond.m_wr || d_wr;
        arm_ok = !cond.m_arm || armed;

        hit_o = cond.en && !consumed && bus_valid &&
                addr_ok && data_ok && rd_ok && wr_ok && arm_ok;
    end

endmodule

// File: rtl/dbg_trig_action_core.sv
module dbg_trig_action_core
    import dbg_trig_pkg::*;
#(
    parameter int N_SLOTS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  act_t [N_SLOTS-1:0]  act,
    input  logic [N_SLOTS-1:0]  hit,
    input  logic [N_SLOTS-1:0]  on_dbus,
    input  logic [N_SLOTS-1:0]  arm_clr,
    output logic                brk_o,
    output logic                ext_o,
    output logic                trace_en_o,
    output logic                smp_o,
    output logic [N_SLOTS-1:0]  armed_o
);

    typedef struct packed {
        logic               brk;
        logic               ext;
        logic               trc;
        logic               smp;
        logic [N_SLOTS-1:0] armed;
    } act_st_t;

    act_st_t st_d, st_q;
    logic    brk_any, ext_any, ton_any, toff_any, smp_any;
    logic [N_SLOTS-1:0] arm_set;

    always_comb begin
        brk_any  = 1'b0;
        ext_any  = 1'b0;
        ton_any  = 1'b0;
        toff_any = 1'b0;
        smp_any  = 1'b0;
        arm_set  = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (hit[i]) begin
                brk_any  = brk_any  | act[i].brk;
                ext_any  = ext_any  | act[i].ext;
                ton_any  = ton_any  | act[i].ton;
                toff_any = toff_any | act[i].toff;
                smp_any  = smp_any  | (act[i].smp & on_dbus[i]);
                for (int t = 0; t < N_SLOTS; t++)
                    if (act[i].arm && act[i].arm_tgt == TGT_W'(t))
                        arm_set[t] = 1'b1;
            end
        end

        st_d       = st_q;
        st_d.brk   = brk_any;
        st_d.ext   = ext_any;
        st_d.smp   = smp_any;
        if (toff_any)      st_d.trc = 1'b0;
        else if (ton_any)  st_d.trc = 1'b1;
        st_d.armed = (st_q.armed & ~arm_clr) | arm_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign brk_o      = st_q.brk;
    assign ext_o      = st_q.ext;
    assign trace_en_o = st_q.trc;
    assign smp_o      = st_q.smp;
    assign armed_o    = st_q.armed;

    // R9: a trace-off event always leaves the flag clear
    p_trace_off_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        toff_any |=> !trace_en_o);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_arm_chk
        // R8: flag survives unless its control word is written
        p_arm_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_o[g] && !arm_clr[g]) |=> armed_o[g]);
        // R8: control write without a new arm event clears the flag
        p_arm_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_clr[g] && !arm_set[g]) |=> !armed_o[g]);
    end

endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit
    import dbg_trig_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int AW      = 32,
    parameter int DW      = 32,
    localparam int IW     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int CW     = (AW > DW) ? ((AW > 28) ? AW : 28) : ((DW > 28) ? DW : 28)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i_valid,
    input  logic [AW-1:0]       i_addr,
    input  logic                d_valid,
    input  logic [AW-1:0]       d_addr,
    input  logic [DW-1:0]       d_data,
    input  logic                d_rd,
    input  logic                d_wr,
    input  logic                cfg_we,
    input  logic [IW-1:0]       cfg_slot,
    input  logic [1:0]          cfg_sel,
    input  logic [CW-1:0]       cfg_wdata,
    output logic                break_o,
    output logic                ext_trig_o,
    output logic                trace_en_o,
    output logic                trace_sample_o,
    output logic [N_SLOTS-1:0]  armed_o
);

    ctrl_t [N_SLOTS-1:0]         ctrl_w;
    act_t  [N_SLOTS-1:0]         act_w;
    logic  [N_SLOTS-1:0][AW-1:0] addr_w;
    logic  [N_SLOTS-1:0][DW-1:0] data_w;
    logic  [N_SLOTS-1:0]         ctrl_wr_w;
    logic  [N_SLOTS-1:0]         hit_w;
    logic  [N_SLOTS-1:0]         dbus_w;

    dbg_trig_cfg_store #(
        .N_SLOTS(N_SLOTS), .AW(AW), .DW(DW), .CW(CW), .IW(IW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .slot      (cfg_slot),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .ctrl_o    (ctrl_w),
        .addr_o    (addr_w),
        .data_o    (data_w),
        .ctrl_wr_o (ctrl_wr_w)
    );

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        localparam bit PAIRED_LO = ((s % 2) == 0) && (s + 1 < N_SLOTS);
        localparam int HI_IDX    = PAIRED_LO ? s + 1 : s;
        logic consumed;

        assign act_w[s] = ctrl_w[s].act;

        if ((s % 2) == 1) begin : g_odd
            assign consumed = ctrl_w[s-1].cond.range;
        end else begin : g_even
            assign consumed = 1'b0;
        end

        dbg_trig_slot_match #(
            .AW(AW), .DW(DW), .HAS_PAIR(PAIRED_LO)
        ) u_match (
            .cond      (ctrl_w[s].cond),
            .lo_addr   (addr_w[s]),
            .lo_data   (data_w[s]),
            .hi_addr   (addr_w[HI_IDX]),
            .hi_data   (data_w[HI_IDX]),
            .consumed  (consumed),
            .armed     (armed_o[s]),
            .i_valid   (i_valid),
            .i_addr    (i_addr),
            .d_valid   (d_valid),
            .d_addr    (d_addr),
            .d_data    (d_data),
            .d_rd      (d_rd),
            .d_wr      (d_wr),
            .on_dbus_o (dbus_w[s]),
            .hit_o     (hit_w[s])
        );
    end

    dbg_trig_action_core #(.N_SLOTS(N_SLOTS)) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act_w),
        .hit        (hit_w),
        .on_dbus    (dbus_w),
        .arm_clr    (ctrl_wr_w),
        .brk_o      (break_o),
        .ext_o      (ext_trig_o),
        .trace_en_o (trace_en_o),
        .smp_o      (trace_sample_o),
        .armed_o    (armed_o)
    );

    // R3: a break pulse always follows a bus transfer
    p_break_needs_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        break_o |-> $past(i_valid || d_valid));

    // R10: sample strobes only follow data-bus transfers
    p_sample_dbus_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trace_sample_o |-> $past(d_valid));

    // R11: an external pulse always follows a bus transfer
    p_ext_needs_xfer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_trig_o |-> $past(i_valid || d_valid));

endmodule

// File: tb/sim_dbg_trigger_unit.sv
module sim_dbg_trigger_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    localparam logic [31:0] C_EN    = 32'h1;
    localparam logic [31:0] C_DBUS  = 32'h2;
    localparam logic [31:0] C_MADDR = 32'h4;
    localparam logic [31:0] C_MDATA = 32'h8;
    localparam logic [31:0] C_MRD   = 32'h10;
    localparam logic [31:0] C_MWR   = 32'h20;
    localparam logic [31:0] C_MARM  = 32'h40;
    localparam logic [31:0] C_RANGE = 32'h80;
    localparam logic [31:0] C_RDATA = 32'h100;
    localparam logic [31:0] A_BRK   = 32'h1 << 16;
    localparam logic [31:0] A_EXT   = 32'h1 << 17;
    localparam logic [31:0] A_TON   = 32'h1 << 18;
    localparam logic [31:0] A_TOFF  = 32'h1 << 19;
    localparam logic [31:0] A_SMP   = 32'h1 << 20;
    localparam logic [31:0] A_ARM   = 32'h1 << 21;

    logic clk = 1'b0;
    logic rst_n;
    logic i_valid, d_valid, d_rd, d_wr, cfg_we;
    logic [31:0] i_addr, d_addr, d_data, cfg_wdata;
    logic [1:0]  cfg_slot, cfg_sel;
    logic break_o, ext_trig_o, trace_en_o, trace_sample_o;
    logic [N-1:0] armed_o;

    logic cap_brk, cap_ext, cap_trc, cap_smp;
    logic [N-1:0] cap_arm;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_trigger_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .i_valid(i_valid), .i_addr(i_addr),
        .d_valid(d_valid), .d_addr(d_addr), .d_data(d_data), .d_rd(d_rd), .d_wr(d_wr),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .break_o(break_o), .ext_trig_o(ext_trig_o), .trace_en_o(trace_en_o),
        .trace_sample_o(trace_sample_o), .armed_o(armed_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic capture();
        cap_brk = break_o;
        cap_ext = ext_trig_o;
        cap_trc = trace_en_o;
        cap_smp = trace_sample_o;
        cap_arm = armed_o;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        i_valid = 0; d_valid = 0; d_rd = 0; d_wr = 0; cfg_we = 0;
        i_addr = 0; d_addr = 0; d_data = 0; cfg_wdata = 0; cfg_slot = 0; cfg_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int slot, input int sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1; cfg_slot = 2'(slot); cfg_sel = 2'(sel); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic ixfer(input logic [31:0] a);
        @(negedge clk);
        i_valid = 1; i_addr = a;
        @(negedge clk);
        capture();
        i_valid = 0;
    endtask

    task automatic dxfer(input logic [31:0] a, input logic [31:0] dv, input logic rd, input logic wrq);
        @(negedge clk);
        d_valid = 1; d_addr = a; d_data = dv; d_rd = rd; d_wr = wrq;
        @(negedge clk);
        capture();
        d_valid = 0; d_rd = 0; d_wr = 0;
    endtask

    task automatic idle();
        @(negedge clk);
        capture();
    endtask

    task automatic t_reset();
        do_reset();
        idle();
        chk("R1 break low", cap_brk, 0);
        chk("R1 ext low", cap_ext, 0);
        chk("R1 trace low", cap_trc, 0);
        chk("R1 sample low", cap_smp, 0);
        chk("R1 armed clear", cap_arm, 0);
        ixfer(32'h0);
        chk("R1 no fire unprogrammed", cap_brk, 0);
    endtask

    task automatic t_iaddr();
        do_reset();
        wr(0, 1, 32'h100);
        wr(0, 0, C_EN | C_MADDR | A_BRK);
        ixfer(32'h100);
        chk("R2 R3 break on ifetch match", cap_brk, 1);
        idle();
        chk("R3 break one cycle", cap_brk, 0);
        ixfer(32'h104);
        chk("R3 no break other addr", cap_brk, 0);
        dxfer(32'h100, 0, 1, 0);
        chk("R3 data bus ignored", cap_brk, 0);
    endtask

    task automatic t_dbus_and();
        do_reset();
        wr(1, 1, 32'h2000);
        wr(1, 0, C_EN | C_DBUS | C_MADDR | C_MWR | A_EXT);
        wr(2, 2, 32'hCAFE);
        wr(2, 0, C_EN | C_DBUS | C_MDATA | C_MRD | A_BRK);
        dxfer(32'h2000, 0, 0, 1);
        chk("R4 write to addr fires", cap_ext, 1);
        chk("R11 ext pulse", cap_ext, 1);
        idle();
        chk("R11 ext one cycle", cap_ext, 0);
        dxfer(32'h2000, 0, 1, 0);
        chk("R4 read to addr silent", cap_ext, 0);
        dxfer(32'h2004, 0, 0, 1);
        chk("R4 write other addr silent", cap_ext, 0);
        dxfer(32'h9000, 32'hCAFE, 1, 0);
        chk("R4 read of data fires", cap_brk, 1);
        dxfer(32'h9000, 32'hCAFE, 0, 1);
        chk("R4 write of data silent", cap_brk, 0);
        dxfer(32'h9000, 32'hCAFF, 1, 0);
        chk("R4 read other data silent", cap_brk, 0);
    endtask

    task automatic t_disabled();
        do_reset();
        wr(0, 1, 32'h300);
        wr(0, 0, C_MADDR | A_BRK | A_EXT | A_TON);
        ixfer(32'h300);
        chk("R5 disabled no break", cap_brk, 0);
        chk("R5 disabled no ext", cap_ext, 0);
        chk("R5 disabled no trace", cap_trc, 0);
    endtask

    task automatic t_range();
        do_reset();
        wr(0, 1, 32'h1000);
        wr(1, 1, 32'h10FF);
        wr(0, 0, C_EN | C_RANGE | A_BRK);
        wr(1, 0, C_EN | C_DBUS | C_MADDR | A_EXT);
        wr(2, 2, 32'd10);
        wr(3, 2, 32'd20);
        wr(2, 0, C_EN | C_RANGE | C_RDATA | A_EXT);
        dxfer(32'h0FFF, 0, 1, 0);
        chk("R6 below low bound", cap_brk, 0);
        dxfer(32'h1000, 0, 1, 0);
        chk("R6 low bound inclusive", cap_brk, 1);
        dxfer(32'h10FF, 0, 1, 0);
        chk("R6 high bound inclusive", cap_brk, 1);
        chk("R6 paired slot silent", cap_ext, 0);
        dxfer(32'h1100, 0, 1, 0);
        chk("R6 above high bound", cap_brk, 0);
        dxfer(32'h5000, 32'd20, 0, 1);
        chk("R6 data high bound", cap_ext, 1);
        dxfer(32'h5000, 32'd21, 0, 1);
        chk("R6 data above", cap_ext, 0);
        dxfer(32'h5000, 32'd9, 0, 1);
        chk("R6 data below", cap_ext, 0);
        dxfer(32'h5000, 32'd10, 0, 1);
        chk("R6 data low bound", cap_ext, 1);
    endtask

    task automatic t_arm();
        do_reset();
        wr(0, 1, 32'hA0);
        wr(0, 0, C_EN | C_DBUS | C_MADDR | A_ARM | (32'd1 << 24));
        wr(1, 1, 32'hB0);
        wr(1, 0, C_EN | C_DBUS | C_MADDR | C_MARM | A_BRK);
        dxfer(32'hB0, 0, 1, 0);
        chk("R7 unarmed silent", cap_brk, 0);
        dxfer(32'hA0, 0, 1, 0);
        chk("R7 arm flag set", cap_arm, 4'b0010);
        chk("R7 arm event no break", cap_brk, 0);
        dxfer(32'hB0, 0, 1, 0);
        chk("R7 armed fires", cap_brk, 1);
        dxfer(32'hB0, 0, 1, 0);
        chk("R8 arm stays latched", cap_brk, 1);
        wr(1, 0, C_EN | C_DBUS | C_MADDR | C_MARM | A_BRK);
        idle();
        chk("R8 ctrl write clears", cap_arm, 4'b0000);
        dxfer(32'hB0, 0, 1, 0);
        chk("R8 cleared silent", cap_brk, 0);
        dxfer(32'hA0, 0, 1, 0);
        wr(1, 1, 32'hB0);
        idle();
        chk("R8 addr write keeps arm", cap_arm, 4'b0010);
        dxfer(32'hB0, 0, 1, 0);
        chk("R8 still fires after addr write", cap_brk, 1);
    endtask

    task automatic t_trace();
        do_reset();
        wr(0, 1, 32'h10);
        wr(0, 0, C_EN | C_DBUS | C_MADDR | A_TON);
        wr(1, 1, 32'h20);
        wr(1, 0, C_EN | C_DBUS | C_MADDR | A_TOFF);
        wr(2, 0, C_EN | C_DBUS | C_MWR | A_TOFF);
        wr(3, 0, C_EN | C_DBUS | C_MWR | A_TON);
        dxfer(32'h10, 0, 1, 0);
        chk("R9 trace on", cap_trc, 1);
        idle();
        chk("R9 trace sticky", cap_trc, 1);
        dxfer(32'h20, 0, 1, 0);
        chk("R9 trace off", cap_trc, 0);
        dxfer(32'h10, 0, 1, 0);
        chk("R9 trace on again", cap_trc, 1);
        dxfer(32'h30, 0, 0, 1);
        chk("R9 off wins", cap_trc, 0);
    endtask

    task automatic t_sample();
        do_reset();
        wr(0, 1, 32'h40);
        wr(0, 0, C_EN | C_MADDR | A_SMP | A_BRK);
        wr(1, 1, 32'h40);
        wr(1, 0, C_EN | C_DBUS | C_MADDR | A_SMP);
        ixfer(32'h40);
        chk("R10 ifetch slot fired", cap_brk, 1);
        chk("R10 ifetch sample suppressed", cap_smp, 0);
        dxfer(32'h40, 0, 1, 0);
        chk("R10 data sample", cap_smp, 1);
        idle();
        chk("R10 sample one cycle", cap_smp, 0);
    endtask

    initial begin
        t_reset();
        t_iaddr();
        t_dbus_and();
        t_disabled();
        t_range();
        t_arm();
        t_trace();
        t_sample();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule